// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup

A direct-mapped read cache whose line storage is split into two banks, so that each index can hold two lines, as in a two-way cache. A per-index predictor bit names the bank that is consulted first. If the tag matches there, the word returns after one cycle as a fast hit. If not, the other bank is consulted in the next cycle. A match there returns after two cycles as a slow hit and moves the predictor to that bank. If neither bank holds the line, the controller asks lower memory for the whole line and raises a stall until the line arrives. It then places the line in the bank that was not predicted, points the predictor at that bank, and returns the requested word.

A request is taken in any cycle where `req_ready` is high. While a request is in flight no new one is taken. The response is a single-cycle `rsp_valid` with the data word and a two-bit class. Lower memory answers a line request with one beat that holds the whole line.

Top module: `pa_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `stall`, `rsp_valid` and `mem_req_valid` are 0. The first access to any index therefore misses.
- R2: When the predicted bank of the index holds a valid line with a matching tag, `rsp_valid` is high in the cycle after the request is taken, with class 1 (fast).
- R3: When only the other bank of the index matches, `rsp_valid` is high two cycles after the request is taken, with class 2 (slow).
- R4: After a slow hit, the predictor of that index points at the bank that hit, so an immediate repeat of the same address is a fast hit.
- R5: When neither bank matches, `mem_req_valid` and `stall` stay high with `mem_req_addr` equal to the request address without its word-offset bits, until a `mem_rsp_valid` beat arrives. `rsp_valid` with class 3 (miss) follows in the next cycle.
- R6: A refilled line goes into the bank that was not predicted, and the predictor then names that bank. The line in the formerly predicted bank survives, and the line in the refilled bank is evicted.
- R7: `req_valid` is ignored while `req_ready` is low. It gives no extra response and has no effect on later lookups.
- R8: A `mem_rsp_valid` beat that arrives while no refill is pending installs nothing, and a later read of that line misses.
- R9: Each request that is taken gives exactly one single-cycle `rsp_valid`.
- R10: The returned word is word number `off` of the line, where `off` is the low OFF_W address bits. Word 0 is in bits DATA_W-1:0 of the line, and each higher word sits DATA_W bits further up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Word address: tag, index, word offset (low bits) |
| req_ready | output | 1 | High when a request can be taken |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | DATA_W | Returned word |
| rsp_class | output | 2 | 1 fast hit, 2 slow hit, 3 miss |
| stall | output | 1 | High while waiting for a refill |
| mem_req_valid | output | 1 | Line request to lower memory, held until answered |
| mem_req_addr | output | ADDR_W-OFF_W | Line address |
| mem_rsp_valid | input | 1 | Refill beat strobe |
| mem_rsp_line | input | DATA_W<<OFF_W | Refill line, word 0 in the low bits |

## Verification
Two things can happen in the same cycle. A response leaves for one request, and the next request is taken while the predictor or a freshly refilled line from the previous request is being written. The bench provokes this by driving every new request in the very cycle that the previous response appears, including the request straight after a slow hit or a refill to the same index. Each outcome is judged against a bench model of tags, valid bits and predictor bits that is updated by the same rules. The model gives the class, the word and the exact latency that are expected.

// File: rtl/pa_cache_pkg.sv
package pa_cache_pkg;
   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_FAST = 2'd1,
      RSP_SLOW = 2'd2,
      RSP_MISS = 2'd3
   } rsp_class_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ALT  = 2'd1,
      ST_FILL = 2'd2
   } probe_state_e;
endpackage

// File: rtl/pa_bank.sv
module pa_bank #(
   parameter int SETS_W = 6,
   parameter int TAG_W  = 8,
   parameter int LINE_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SETS_W-1:0] rd_set,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [SETS_W-1:0] wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);
   localparam int SETS = 1 << SETS_W;

   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_set]  <= wr_tag;
         line_q[wr_set] <= wr_line;
      end
   end

   assign rd_hit  = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
   assign rd_line = line_q[rd_set];

   a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(vld_q));
   a_r6_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_set)]);
endmodule

// File: rtl/pa_predictor.sv
module pa_predictor #(
   parameter int SETS_W    = 6,
   parameter bit PRED_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SETS_W-1:0] rd_set,
   output logic              rd_bank,
   input  logic              upd_en,
   input  logic [SETS_W-1:0] upd_set,
   input  logic              upd_bank
);
   localparam int SETS = 1 << SETS_W;

   logic [SETS-1:0] pred_q;
   logic [SETS-1:0] init_vec;

   generate
      if (PRED_INIT) begin : g_init_one
         assign init_vec = '1;
      end else begin : g_init_zero
         assign init_vec = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_q <= init_vec;
      end else if (upd_en) begin
         pred_q[upd_set] <= upd_bank;
      end
   end

   assign rd_bank = pred_q[rd_set];

   a_r4_pred_update: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (pred_q[$past(upd_set)] == $past(upd_bank)));
endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
   import pa_cache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SETS_W = 6,
   parameter int OFF_W  = 2,
   parameter int DATA_W = 16,
   localparam int TAG_W  = ADDR_W - SETS_W - OFF_W,
   localparam int LINE_W = DATA_W << OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic [SETS_W-1:0]       look_set,
   output logic [TAG_W-1:0]        look_tag,
   input  logic                    pred_bank,
   input  logic [1:0]              hit_vec,
   input  logic [1:0][LINE_W-1:0]  line_vec,
   output logic                    upd_en,
   output logic [SETS_W-1:0]       upd_set,
   output logic                    upd_bank,
   output logic                    fill_en,
   output logic                    fill_bank,
   output logic [SETS_W-1:0]       fill_set,
   output logic [TAG_W-1:0]        fill_tag,
   output logic [LINE_W-1:0]       fill_line,
   output logic                    mem_req_valid,
   output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [LINE_W-1:0]       mem_rsp_line,
   output logic                    rsp_valid,
   output logic [DATA_W-1:0]       rsp_data,
   output logic [1:0]              rsp_class,
   output logic                    stall
);
   probe_state_e      st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [OFF_W-1:0]  cur_off;
   logic              pbank_q;
   logic              alt_bank;
   logic              accept;

   function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                   input logic [OFF_W-1:0]  o);
      return ln[int'(o)*DATA_W +: DATA_W];
   endfunction

   assign cur_addr = (st_q == ST_IDLE) ? req_addr : addr_q;
   assign look_set = cur_addr[OFF_W +: SETS_W];
   assign look_tag = cur_addr[ADDR_W-1 -: TAG_W];
   assign cur_off  = cur_addr[OFF_W-1:0];
   assign alt_bank = ~pbank_q;
   assign accept   = (st_q == ST_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         pbank_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_class <= RSP_NONE;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  pbank_q <= pred_bank;
                  if (hit_vec[pred_bank]) begin
                     rsp_valid <= 1'b1;
                     rsp_class <= RSP_FAST;
                     rsp_data  <= pick_word(line_vec[pred_bank], cur_off);
                  end else begin
                     st_q <= ST_ALT;
                  end
               end
            end
            ST_ALT: begin
               if (hit_vec[alt_bank]) begin
                  rsp_valid <= 1'b1;
                  rsp_class <= RSP_SLOW;
                  rsp_data  <= pick_word(line_vec[alt_bank], cur_off);
                  st_q      <= ST_IDLE;
               end else begin
                  st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_class <= RSP_MISS;
                  rsp_data  <= pick_word(mem_rsp_line, cur_off);
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_FILL);
   assign stall         = (st_q == ST_FILL);
   assign mem_req_addr  = addr_q[ADDR_W-1:OFF_W];

   assign fill_en   = (st_q == ST_FILL) && mem_rsp_valid;
   assign fill_bank = alt_bank;
   assign fill_set  = addr_q[OFF_W +: SETS_W];
   assign fill_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign fill_line = mem_rsp_line;

   assign upd_en   = ((st_q == ST_ALT) && hit_vec[alt_bank]) || fill_en;
   assign upd_set  = addr_q[OFF_W +: SETS_W];
   assign upd_bank = alt_bank;

   a_r2_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit_vec[pred_bank]) |=> (rsp_valid && rsp_class == RSP_FAST));
   a_r3_slow_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ALT && hit_vec[alt_bank]) |=> (rsp_valid && rsp_class == RSP_SLOW));
   a_r5_line_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && $past(mem_req_valid)) |-> $stable(mem_req_addr));
   a_r7_busy_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && $past(st_q != ST_IDLE)) |-> $stable(addr_q));
   a_r9_rsp_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(st_q != ST_IDLE || req_valid));
endmodule

// File: rtl/pa_cache.sv
module pa_cache
   import pa_cache_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SETS_W    = 6,
   parameter int OFF_W     = 2,
   parameter int DATA_W    = 16,
   parameter bit PRED_INIT = 1'b0,
   localparam int TAG_W  = ADDR_W - SETS_W - OFF_W,
   localparam int LINE_W = DATA_W << OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic [DATA_W-1:0]       rsp_data,
   output logic [1:0]              rsp_class,
   output logic                    stall,
   output logic                    mem_req_valid,
   output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [LINE_W-1:0]       mem_rsp_line
);
   initial begin
      assert (OFF_W >= 1 && OFF_W <= 4) else $error("pa_cache: OFF_W out of range");
      assert (SETS_W >= 1 && SETS_W <= 8) else $error("pa_cache: SETS_W out of range");
      assert (TAG_W >= 1) else $error("pa_cache: no tag bits left");
      assert (DATA_W >= 1) else $error("pa_cache: DATA_W must be positive");
   end

   logic [SETS_W-1:0]      look_set;
   logic [TAG_W-1:0]       look_tag;
   logic                   pred_bank;
   logic [1:0]             hit_vec;
   logic [1:0][LINE_W-1:0] line_vec;
   logic                   upd_en;
   logic [SETS_W-1:0]      upd_set;
   logic                   upd_bank;
   logic                   fill_en;
   logic                   fill_bank;
   logic [SETS_W-1:0]      fill_set;
   logic [TAG_W-1:0]       fill_tag;
   logic [LINE_W-1:0]      fill_line;

   pa_predictor #(.SETS_W(SETS_W), .PRED_INIT(PRED_INIT)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (look_set),
      .rd_bank  (pred_bank),
      .upd_en   (upd_en),
      .upd_set  (upd_set),
      .upd_bank (upd_bank)
   );

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic bank_we;
         assign bank_we = fill_en && (fill_bank == b[0]);
         pa_bank #(.SETS_W(SETS_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_set  (look_set),
            .rd_tag  (look_tag),
            .rd_hit  (hit_vec[b]),
            .rd_line (line_vec[b]),
            .wr_en   (bank_we),
            .wr_set  (fill_set),
            .wr_tag  (fill_tag),
            .wr_line (fill_line)
         );
      end
   endgenerate

   pa_ctrl #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_ready     (req_ready),
      .look_set      (look_set),
      .look_tag      (look_tag),
      .pred_bank     (pred_bank),
      .hit_vec       (hit_vec),
      .line_vec      (line_vec),
      .upd_en        (upd_en),
      .upd_set       (upd_set),
      .upd_bank      (upd_bank),
      .fill_en       (fill_en),
      .fill_bank     (fill_bank),
      .fill_set      (fill_set),
      .fill_tag      (fill_tag),
      .fill_line     (fill_line),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_line  (mem_rsp_line),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data),
      .rsp_class     (rsp_class),
      .stall         (stall)
   );

   a_r1_never_both_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_vec[0] && hit_vec[1]));
   a_r6_fill_clears_stall: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (!stall && rsp_valid && rsp_class == RSP_MISS));
endmodule

// File: tb/pa_cache_test.sv
module pa_cache_test;
   localparam int ADDR_W  = 8;
   localparam int SETS_W  = 2;
   localparam int OFF_W   = 1;
   localparam int DATA_W  = 16;
   localparam int LINE_W  = DATA_W << OFF_W;
   localparam int MEM_LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_ready;
   logic rsp_valid;
   logic [DATA_W-1:0] rsp_data;
   logic [1:0] rsp_class;
   logic stall;
   logic mem_req_valid;
   logic [ADDR_W-OFF_W-1:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [LINE_W-1:0] mem_rsp_line = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int last_cls = 0;

   bit       mv [4][2];
   bit [4:0] mt [4][2];
   bit       mp [4];

   always #4 clk = ~clk;

   pa_cache #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_class(rsp_class), .stall(stall), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_line(mem_rsp_line)
   );

   function automatic logic [15:0] word_of(input logic [7:0] a);
      return 16'((int'(a) * 40503 + 4660) ^ (int'(a) << 5));
   endfunction

   function automatic logic [31:0] line_of(input logic [6:0] l);
      return {word_of({l, 1'b1}), word_of({l, 1'b0})};
   endfunction

   function automatic logic [7:0] mk(input int tag, input int set, input int off);
      return {tag[4:0], set[1:0], off[0]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge where the response is visible.
   task automatic rd(input logic [7:0] a, input bit poke);
      int s, lat, cls, n, cnt;
      bit p;
      logic [4:0] tg;
      string lbl;
      s  = int'(a[2:1]);
      tg = a[7:3];
      p  = mp[s];
      if (mv[s][p] && mt[s][p] == tg) begin
         cls = 1; lat = 1; lbl = "R2";
      end else if (mv[s][!p] && mt[s][!p] == tg) begin
         cls = 2; lat = 2; lbl = "R3";
         mp[s] = !p;
      end else begin
         cls = 3; lat = MEM_LAT + 2; lbl = "R5";
         mv[s][!p] = 1'b1;
         mt[s][!p] = tg;
         mp[s] = !p;
      end
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      cnt = 0;
      while (!rsp_valid && n < 40) begin
         if (mem_req_valid) begin
            cnt++;
            chk(stall == 1'b1, "R5 stall", int'(stall), 1);
            if (cnt == 1) begin
               chk(mem_req_addr == a[7:1], "R5 line address", int'(mem_req_addr), int'(a[7:1]));
               if (poke) begin
                  req_valid = 1'b1;        // R7: request while not ready
                  req_addr  = ~a;
               end
            end
            if (cnt == MEM_LAT) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_line  = line_of(mem_req_addr);
            end
         end
         @(negedge clk);
         n++;
         mem_rsp_valid = 1'b0;
         req_valid = 1'b0;
      end
      last_cls = int'(rsp_class);
      chk(rsp_valid == 1'b1, {lbl, " response"}, int'(rsp_valid), 1);
      chk(int'(rsp_class) == cls, {lbl, " class"}, int'(rsp_class), cls);
      chk(rsp_data == word_of(a), "R10 word", int'(rsp_data), int'(word_of(a)));
      chk(n == lat, {lbl, " latency"}, n, lat);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         mp[s] = 1'b0;
         for (int b = 0; b < 2; b++) begin
            mv[s][b] = 1'b0;
            mt[s][b] = '0;
         end
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
      chk(stall == 1'b0, "R1 stall", int'(stall), 0);
      chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first touch of every index misses
      for (int s = 0; s < 4; s++) begin
         rd(mk(0, s, s & 1), 1'b0);
         chk(last_cls == 3, "R1 first access", last_cls, 3);
      end
      // R9: single-cycle response
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 pulse", int'(rsp_valid), 0);
      // Directed placement and predictor sequence on index 0
      rd(mk(1, 0, 0), 1'b0);
      chk(last_cls == 3, "R6 new tag miss", last_cls, 3);
      rd(mk(0, 0, 1), 1'b0);
      chk(last_cls == 2, "R6 older line kept", last_cls, 2);
      rd(mk(0, 0, 0), 1'b0);
      chk(last_cls == 1, "R4 flipped predictor", last_cls, 1);
      rd(mk(2, 0, 1), 1'b0);
      chk(last_cls == 3, "R6 third tag miss", last_cls, 3);
      rd(mk(1, 0, 0), 1'b0);
      chk(last_cls == 3, "R6 non-predicted evicted", last_cls, 3);
      rd(mk(2, 0, 0), 1'b0);
      chk(last_cls == 2, "R3 slow after refill", last_cls, 2);
      // R7: request during a refill
      rd(mk(5, 2, 1), 1'b1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 no extra response", int'(rsp_valid), 0);
      rd(mk(5, 2, 0), 1'b0);
      chk(last_cls == 1, "R7 state untouched", last_cls, 1);
      // R8: stray refill beat while idle
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_line  = line_of(mk(31, 1, 0) >> 1);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R8 no response", int'(rsp_valid), 0);
      chk(stall == 1'b0, "R8 no stall", int'(stall), 0);
      rd(mk(31, 1, 0), 1'b0);
      chk(last_cls == 3, "R8 line not installed", last_cls, 3);
      // Exhaustive sweep of small space, back to back
      for (int t = 0; t < 4; t++)
         for (int s = 0; s < 4; s++)
            for (int o = 0; o < 2; o++)
               rd(mk(t, s, o), 1'b0);
      // Conflict-heavy arithmetic sequence with occasional pokes
      for (int i = 0; i < 400; i++) begin
         int v;
         v = (i * 37 + (i >> 2) * 11 + (i >> 5)) % 24;
         rd(mk(v / 8, (v / 2) % 4, v % 2), (i % 7) == 3);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule